// File: doc/BRIEF.md
# Peak Per-Frame Processing Cycle Monitor

This block measures how many clock cycles a transmit process spends on each frame. It keeps the worst case seen since the last clear. A single-cycle frame-start pulse opens a measurement. A single-cycle done pulse closes it once every scheduler entry for that frame has been handled. The closed length replaces the stored peak only when it is larger.

The peak register is wide enough to hold far more cycles than one frame period. A frame that takes too long therefore shows up as a value above the nominal period. An overrun flag compares the peak with a cycles-per-frame limit supplied on a port, so higher-level logic can react to a late frame without doing its own compare. A clear input resets the peak to zero; it is meant to be driven from a software write strobe.

Top module: `peak_cycle_mon`

## Requirements
- R1: After reset, `peak_o` is 0 and `overrun_o` is 0.
- R2: With start accepted at clock edge k and done at edge k+N (N >= 1), the measured length is N. When N is larger than the stored peak, `peak_o` reads N from the cycle after edge k+N.
- R3: A measured length that is not larger than the stored peak leaves `peak_o` unchanged.
- R4: `clear_i` sampled high sets `peak_o` to 0 on the next cycle. This holds even when a measurement closes at that same edge with a larger value.
- R5: A start pulse while a frame is still open closes the open measurement with its length so far, compares it like a done, and begins a new measurement at that edge.
- R6: A done pulse while no frame is open is ignored and leaves `peak_o` unchanged.
- R7: The measured length saturates at 2^CNT_W-1 and never wraps. With CNT_W=5, a 40-cycle frame reads 31.
- R8: `overrun_o` is high exactly when `peak_o` is greater than `limit_i`.
- R9: A frame longer than one frame period (7000 cycles against a 6250-cycle limit at default CNT_W=16) is recorded exactly, and the overrun flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame-received pulse, opens a measurement |
| done_i | input | 1 | All entries of the frame handled, closes the measurement |
| clear_i | input | 1 | Clears the stored peak |
| limit_i | input | CNT_W | Cycles-per-frame threshold for the overrun flag |
| peak_o | output | CNT_W | Largest measured frame length since the last clear |
| overrun_o | output | 1 | Peak exceeds `limit_i` |

## Verification
A counter that starts one cycle late or stops one cycle early shows at `peak_o` as an off-by-one length, one cycle after the closing pulse. The directed frames use exact lengths of 1, 5, 7 and 7000 to expose this. A measurement state that stays open after done, or opens on a stray done, only shows on a later frame or a later idle done. The bench therefore follows each such case with a second pulse and reads the peak again. A counter that wraps instead of saturating shows a small value where 31 is expected on a narrow instance.

// File: rtl/peak_mon_pkg.sv
package peak_mon_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  typedef enum logic {MEAS_IDLE = 1'b0, MEAS_RUN = 1'b1} meas_state_e;
endpackage

// File: rtl/peak_frame_counter.sv
module peak_frame_counter
  import peak_mon_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  output logic             close_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             open_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  meas_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  // saturating increment: length including the current edge
  assign cnt_inc = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign close_o = (state_q == MEAS_RUN) && (start_i || done_i);
  assign meas_o  = cnt_inc;
  assign open_o  = (state_q == MEAS_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MEAS_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= MEAS_RUN;
      cnt_q   <= '0;
    end else if (done_i && state_q == MEAS_RUN) begin
      state_q <= MEAS_IDLE;
      cnt_q   <= '0;
    end else if (state_q == MEAS_RUN) begin
      cnt_q   <= cnt_inc;
    end
  end

  assert_cnt_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MEAS_RUN && !start_i && !done_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  assert_start_opens_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == MEAS_RUN && cnt_q == '0));
endmodule

// File: rtl/peak_hold_reg.sv
module peak_hold_reg #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [CNT_W-1:0] peak_o
);
  logic [CNT_W-1:0] peak_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      peak_q <= '0;
    else if (clear_i)                 peak_q <= '0;  // clear wins over update
    else if (upd_i && val_i > peak_q) peak_q <= val_i;
  end

  assign peak_o = peak_q;

  assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (peak_o == '0));

  assert_peak_no_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (peak_o >= $past(peak_o)));

  assert_peak_takes_larger_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && upd_i && val_i > peak_o) |=> (peak_o == $past(val_i)));
endmodule

// File: rtl/overrun_flag.sv
module overrun_flag #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] peak_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             over_o
);
  assign over_o = (peak_i > limit_i);
endmodule

// File: rtl/peak_cycle_mon.sv
module peak_cycle_mon
  import peak_mon_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] peak_o,
  output logic             overrun_o
);
  logic             close;
  logic             meas_open;
  logic [CNT_W-1:0] meas;

  peak_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .done_i  (done_i),
    .close_o (close),
    .meas_o  (meas),
    .open_o  (meas_open)
  );

  peak_hold_reg #(.CNT_W(CNT_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .upd_i   (close),
    .val_i   (meas),
    .peak_o  (peak_o)
  );

  overrun_flag #(.CNT_W(CNT_W)) u_ovr (
    .peak_i  (peak_o),
    .limit_i (limit_i),
    .over_o  (overrun_o)
  );

  assert_idle_done_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_open && done_i && !start_i && !clear_i) |=> $stable(peak_o));

  assert_zero_peak_no_overrun_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peak_o == '0) |-> !overrun_o);
endmodule

// File: tb/peak_cycle_mon_tb.sv
module peak_cycle_mon_tb_top;
  localparam int W  = 16;
  localparam int SW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, done = 1'b0, clear = 1'b0;
  logic [W-1:0]  limit = 16'd6250;
  logic [W-1:0]  peak;
  logic          over;
  logic [SW-1:0] s_peak;
  logic          s_over;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  peak_cycle_mon #(.CNT_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done), .clear_i(clear),
    .limit_i(limit), .peak_o(peak), .overrun_o(over));

  peak_cycle_mon #(.CNT_W(SW)) sat_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done), .clear_i(clear),
    .limit_i(limit[SW-1:0]), .peak_o(s_peak), .overrun_o(s_over));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_clear();
    @(negedge clk) clear = 1'b1;
    @(negedge clk) clear = 1'b0;
  endtask

  // start at edge k, done at edge k+len; returns at negedge after done edge
  task automatic run_frame(input int len);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (len - 1) @(negedge clk);
    done = 1'b1;
    @(negedge clk) done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 peak", int'(peak), 0);
    chk("R1 overrun", int'(over), 0);
  endtask

  task automatic t_basic();
    do_clear();
    run_frame(5);
    chk("R2 len5", int'(peak), 5);
    run_frame(1);
    chk("R3 smaller keeps", int'(peak), 5);
    run_frame(9);
    chk("R2 len9", int'(peak), 9);
    run_frame(9);
    chk("R3 equal keeps", int'(peak), 9);
  endtask

  task automatic t_clear();
    do_clear();
    chk("R4 clear", int'(peak), 0);
    run_frame(3);
    chk("R2 after clear", int'(peak), 3);
    // clear coinciding with a closing done of 12
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (11) @(negedge clk);
    done = 1'b1; clear = 1'b1;
    @(negedge clk) done = 1'b0; clear = 1'b0;
    chk("R4 clear priority", int'(peak), 0);
  endtask

  task automatic t_restart();
    do_clear();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1;                      // second start at edge k+7
    @(negedge clk) start = 1'b0;
    chk("R5 restart closes", int'(peak), 7);
    repeat (2) @(negedge clk);
    done = 1'b1;                       // closes new frame with 3
    @(negedge clk) done = 1'b0;
    chk("R5 new frame smaller", int'(peak), 7);
    do_clear();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (7) @(negedge clk);
    start = 1'b1;                      // closes 8
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    done = 1'b1;                       // new frame closes 11
    @(negedge clk) done = 1'b0;
    chk("R5 new frame counted from restart", int'(peak), 11);
  endtask

  task automatic t_idle_done();
    do_clear();
    run_frame(4);
    @(negedge clk) done = 1'b1;        // no frame open
    @(negedge clk) done = 1'b0;
    chk("R6 idle done", int'(peak), 4);
    repeat (20) @(negedge clk);
    done = 1'b1;
    @(negedge clk) done = 1'b0;
    chk("R6 idle done late", int'(peak), 4);
  endtask

  task automatic t_saturate();
    do_clear();
    run_frame(40);
    chk("R7 saturate narrow", int'(s_peak), 31);
    chk("R7 wide exact", int'(peak), 40);
  endtask

  task automatic t_overrun();
    do_clear();
    limit = 16'd6250;
    run_frame(6000);
    chk("R8 below limit peak", int'(peak), 6000);
    chk("R8 below limit flag", int'(over), 0);
    run_frame(7000);
    chk("R9 long frame exact", int'(peak), 7000);
    chk("R9 overrun raised", int'(over), 1);
    @(negedge clk) limit = 16'd7000;
    #1 chk("R8 equal to limit", int'(over), 0);
    @(negedge clk) limit = 16'd6999;
    #1 chk("R8 one above limit", int'(over), 1);
    do_clear();
    chk("R8 cleared flag", int'(over), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_restart();
    t_idle_done();
    t_saturate();
    t_overrun();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule